// File: doc/BRIEF.md
# Vector Register Scoreboard

This block keeps the hazard state of one SIMD lane group's vector register file. Each physical register carries two status flags. The pending flag is raised when an instruction that writes the register issues. The locked flag is raised when that instruction executes, and at the same edge the pending flag drops. An operand wider than 32 bits occupies its named register and the following one, counted modulo the register count, so a wide operand at the top index also covers register 0.

The scheduler asks the block, one candidate instruction at a time, whether all of its vector operands are free. A register is free only when both of its flags are clear. When the scheduler marks a query as valid and the instruction is blocked, one of two saturating stall counters advances. The lowest-numbered blocking operand decides which one: a destination counts as a write-after-any stall and a source counts as a read-after-write stall.

The locked flag is released in one of two ways. Ordinary instructions load a countdown slot whose length depends on operand width. Loads and atomics are flagged as deferred at execute and wait for a completion beat that names the register, its width and an extra delay; that beat also uses a slot. The execute and completion ports stall when the slot pool cannot take their requests. The register count must be even and a multiple of the allocation granule, and elaboration stops with an error otherwise.

Top module: `vreg_scoreboard`

## Requirements
- R1: After reset every pending and locked flag is clear, both stall counters read zero, every query reports ready, and both the execute and completion ports report ready.
- R2: An operand with its wide bit set covers register i and register (i+1) mod NUM_REGS for every set, clear and check, so a wide operand at index 63 also covers register 0. An operand with the wide bit clear covers register i only.
- R3: A query operand whose enable bit is set is blocked when any register it covers has its pending or locked flag set. `q_ready` is high only when no enabled operand is blocked. Operands whose enable bit is clear are ignored.
- R4: When `iss_valid` is high, each destination with its enable bit set has its covered registers marked pending at the next edge. A pending flag on its own blocks a query.
- R5: An accepted execute (`ex_valid` and `ex_ready`) sets the locked flag and clears the pending flag of every covered destination register at the same edge. If an issue targets the same register at that edge, the issue's pending mark wins.
- R6: For an accepted execute with `ex_deferred` low, the locked flag is released SP_LAT edges after the accepting edge for a narrow destination (4 by default) and DP_LAT edges after it for a wide destination (8 by default).
- R7: For an accepted execute with `ex_deferred` high, the locked flag stays set until a completion beat for that register is accepted. A completion accepted with `cmp_delay` = D releases the register D+1 edges after its accepting edge.
- R8: On every edge where `q_valid` is high and the instruction is blocked, exactly one counter increments. `stall_waw` increments if the lowest-indexed blocking operand has `q_is_dst` set, and `stall_raw` increments otherwise. Neither counter changes while `q_valid` is low.
- R9: Each stall counter holds at its all-ones value instead of wrapping.
- R10: `ex_ready` is low exactly when ex_deferred is low and fewer countdown slots are free than the number of enabled destinations. A deferred execute never needs a slot. `cmp_ready` is low when no slot is left after the slots taken by an execute accepted in the same cycle.
- R11: If a countdown expires for a register at the same edge as a new execute marks it locked, the register stays locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue strobe; marks destinations pending |
| iss_mask | input | MAX_DST | Per-destination enable at issue |
| iss_idx | input | MAX_DST x IDX_W | Physical destination indices at issue |
| iss_wide | input | MAX_DST | Per-destination wide (two-register) flag at issue |
| ex_valid | input | 1 | Execute request |
| ex_ready | output | 1 | Execute can be accepted this cycle |
| ex_deferred | input | 1 | Load or atomic: release waits for completion |
| ex_mask | input | MAX_DST | Per-destination enable at execute |
| ex_idx | input | MAX_DST x IDX_W | Physical destination indices at execute |
| ex_wide | input | MAX_DST | Per-destination wide flag at execute |
| cmp_valid | input | 1 | Completion beat for one destination |
| cmp_ready | output | 1 | Completion beat can be accepted |
| cmp_idx | input | IDX_W | Register released by the completion |
| cmp_wide | input | 1 | Completion covers a register pair |
| cmp_delay | input | DLY_W | Extra edges before release |
| q_valid | input | 1 | Scheduler really wants to issue; enables stall counting |
| q_mask | input | MAX_OPS | Per-operand enable of the query |
| q_idx | input | MAX_OPS x IDX_W | Physical operand indices |
| q_wide | input | MAX_OPS | Per-operand wide flag |
| q_is_dst | input | MAX_OPS | Operand is a destination (1) or a source (0) |
| q_ready | output | 1 | All enabled operands free |
| stall_raw | output | STALL_W | Saturating read-after-write stall count |
| stall_waw | output | STALL_W | Saturating write-after-any stall count |

## Verification
Narrow and wide destinations are placed at the bottom, middle and top of the index space. Each one is checked first for its pending block and then for the number of cycles its lock lasts, which shows the difference between the two release lengths and between wrapped and unwrapped pairs. Deferred executes are held for a long time and then released with different completion delays, which separates timer release from external release. Queries that mix free, destination-blocked and source-blocked operands in different positions show which operand the stall counter classifies. A slot-exhausting burst and a mark that lands on the expiry edge exercise back-pressure and the same-edge priority.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    localparam int unsigned DEF_REGS    = 64;
    localparam int unsigned DEF_SP_LAT  = 4;
    localparam int unsigned DEF_DP_LAT  = 8;
    localparam int unsigned DEF_STALL_W = 32;

    typedef enum logic [1:0] {
        STALL_NONE = 2'd0,
        STALL_RAW  = 2'd1,
        STALL_WAW  = 2'd2
    } stall_kind_e;

    // Does an operand starting at 'base' (pair when 'wide') cover register r?
    function automatic logic covers(input int r, input int base,
                                    input logic wide, input int n);
        return (base == r) || (wide && (((base + 1) % n) == r));
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vsb_status.sv
module vsb_status
    import vsb_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 64,
    parameter int unsigned MAX_DST   = 2,
    parameter int unsigned NUM_SLOTS = 4,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              iss_fire,
    input  logic [MAX_DST-1:0]                iss_mask,
    input  logic [MAX_DST-1:0][IDX_W-1:0]     iss_idx,
    input  logic [MAX_DST-1:0]                iss_wide,
    input  logic                              ex_fire,
    input  logic [MAX_DST-1:0]                ex_mask,
    input  logic [MAX_DST-1:0][IDX_W-1:0]     ex_idx,
    input  logic [MAX_DST-1:0]                ex_wide,
    input  logic [NUM_SLOTS-1:0]              rel_hit,
    input  logic [NUM_SLOTS-1:0][IDX_W-1:0]   rel_idx,
    input  logic [NUM_SLOTS-1:0]              rel_wide,
    output logic [NUM_REGS-1:0]               pend,
    output logic [NUM_REGS-1:0]               lock
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic pend_q, lock_q;
        logic pend_set, pend_clr, lock_set, lock_clr;

        always_comb begin
            pend_set = 1'b0;
            pend_clr = 1'b0;
            lock_set = 1'b0;
            lock_clr = 1'b0;
            for (int k = 0; k < int'(MAX_DST); k++) begin
                if (iss_fire && iss_mask[k] &&
                    covers(r, int'(iss_idx[k]), iss_wide[k], NUM_REGS))
                    pend_set = 1'b1;
                if (ex_fire && ex_mask[k] &&
                    covers(r, int'(ex_idx[k]), ex_wide[k], NUM_REGS)) begin
                    pend_clr = 1'b1;
                    lock_set = 1'b1;
                end
            end
            for (int s = 0; s < int'(NUM_SLOTS); s++) begin
                if (rel_hit[s] && covers(r, int'(rel_idx[s]), rel_wide[s], NUM_REGS))
                    lock_clr = 1'b1;
            end
        end

        // Newer events win: issue over execute-clear, execute over release.
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= 1'b0;
                lock_q <= 1'b0;
            end else begin
                if (pend_set)      pend_q <= 1'b1;
                else if (pend_clr) pend_q <= 1'b0;
                if (lock_set)      lock_q <= 1'b1;
                else if (lock_clr) lock_q <= 1'b0;
            end
        end

        assign pend[r] = pend_q;
        assign lock[r] = lock_q;
    end

endmodule

// File: rtl/vsb_release_pool.sv
module vsb_release_pool
    import vsb_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 64,
    parameter int unsigned MAX_DST   = 2,
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned SP_LAT    = 4,
    parameter int unsigned DP_LAT    = 8,
    parameter int unsigned DLY_W     = 4,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS),
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS + 1),
    localparam int unsigned LIM      = max_of(max_of(SP_LAT, DP_LAT), 1 << DLY_W),
    localparam int unsigned CNT_W    = $clog2(LIM + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ex_take,
    input  logic [MAX_DST-1:0]                ex_mask,
    input  logic [MAX_DST-1:0][IDX_W-1:0]     ex_idx,
    input  logic [MAX_DST-1:0]                ex_wide,
    input  logic                              cmp_take,
    input  logic [IDX_W-1:0]                  cmp_idx,
    input  logic                              cmp_wide,
    input  logic [DLY_W-1:0]                  cmp_delay,
    output logic [SLOT_W-1:0]                 free_cnt,
    output logic [NUM_SLOTS-1:0]              rel_hit,
    output logic [NUM_SLOTS-1:0][IDX_W-1:0]   rel_idx,
    output logic [NUM_SLOTS-1:0]              rel_wide
);

    typedef struct packed {
        logic             live;
        logic             wide;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] left;
    } slot_t;

    slot_t [NUM_SLOTS-1:0] slot_q, slot_d;
    logic  [NUM_SLOTS-1:0] taken;
    logic                  placed;

    always_comb begin
        slot_d = slot_q;
        taken  = '0;
        placed = 1'b0;
        // age live slots; a slot at one retires this edge
        for (int s = 0; s < int'(NUM_SLOTS); s++) begin
            if (slot_q[s].live) begin
                slot_d[s].left = slot_q[s].left - 1'b1;
                if (slot_q[s].left == CNT_W'(1))
                    slot_d[s].live = 1'b0;
            end
        end
        // execute destinations take the lowest free slots in order
        for (int k = 0; k < int'(MAX_DST); k++) begin
            placed = 1'b0;
            if (ex_take && ex_mask[k]) begin
                for (int s = 0; s < int'(NUM_SLOTS); s++) begin
                    if (!placed && !slot_q[s].live && !taken[s]) begin
                        placed         = 1'b1;
                        taken[s]       = 1'b1;
                        slot_d[s].live = 1'b1;
                        slot_d[s].wide = ex_wide[k];
                        slot_d[s].idx  = ex_idx[k];
                        slot_d[s].left = ex_wide[k] ? CNT_W'(DP_LAT) : CNT_W'(SP_LAT);
                    end
                end
            end
        end
        // completion takes the next free slot
        placed = 1'b0;
        if (cmp_take) begin
            for (int s = 0; s < int'(NUM_SLOTS); s++) begin
                if (!placed && !slot_q[s].live && !taken[s]) begin
                    placed         = 1'b1;
                    taken[s]       = 1'b1;
                    slot_d[s].live = 1'b1;
                    slot_d[s].wide = cmp_wide;
                    slot_d[s].idx  = cmp_idx;
                    slot_d[s].left = CNT_W'(cmp_delay) + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    always_comb begin
        free_cnt = '0;
        for (int s = 0; s < int'(NUM_SLOTS); s++) begin
            free_cnt   = free_cnt + SLOT_W'(!slot_q[s].live);
            rel_hit[s] = slot_q[s].live && (slot_q[s].left == CNT_W'(1));
            rel_idx[s] = slot_q[s].idx;
            rel_wide[s] = slot_q[s].wide;
        end
    end

endmodule

// File: rtl/vsb_hazard.sv
module vsb_hazard
    import vsb_pkg::*;
#(
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned MAX_OPS  = 4,
    parameter int unsigned STALL_W  = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_REGS-1:0]             pend,
    input  logic [NUM_REGS-1:0]             lock,
    input  logic                            q_valid,
    input  logic [MAX_OPS-1:0]              q_mask,
    input  logic [MAX_OPS-1:0][IDX_W-1:0]   q_idx,
    input  logic [MAX_OPS-1:0]              q_wide,
    input  logic [MAX_OPS-1:0]              q_is_dst,
    output logic                            q_ready,
    output logic [STALL_W-1:0]              stall_raw,
    output logic [STALL_W-1:0]              stall_waw
);

    logic [NUM_REGS-1:0] held;
    logic [MAX_OPS-1:0]  blk;
    stall_kind_e         kind;

    assign held = pend | lock;

    always_comb begin
        for (int k = 0; k < int'(MAX_OPS); k++) begin
            blk[k] = 1'b0;
            for (int r = 0; r < int'(NUM_REGS); r++) begin
                if (q_mask[k] && held[r] && covers(r, int'(q_idx[k]), q_wide[k], NUM_REGS))
                    blk[k] = 1'b1;
            end
        end
    end

    assign q_ready = ~|blk;

    // descending walk so the lowest blocking operand decides
    always_comb begin
        kind = STALL_NONE;
        for (int k = int'(MAX_OPS) - 1; k >= 0; k--) begin
            if (blk[k]) kind = q_is_dst[k] ? STALL_WAW : STALL_RAW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_raw <= '0;
            stall_waw <= '0;
        end else if (q_valid) begin
            if (kind == STALL_RAW && stall_raw != '1) stall_raw <= stall_raw + 1'b1;
            if (kind == STALL_WAW && stall_waw != '1) stall_waw <= stall_waw + 1'b1;
        end
    end

endmodule

// File: rtl/vreg_scoreboard.sv
module vreg_scoreboard
    import vsb_pkg::*;
#(
    parameter int unsigned NUM_REGS  = DEF_REGS,
    parameter int unsigned MIN_ALLOC = 4,
    parameter int unsigned MAX_DST   = 2,
    parameter int unsigned MAX_OPS   = 4,
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned SP_LAT    = DEF_SP_LAT,
    parameter int unsigned DP_LAT    = DEF_DP_LAT,
    parameter int unsigned DLY_W     = 4,
    parameter int unsigned STALL_W   = DEF_STALL_W,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS),
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            iss_valid,
    input  logic [MAX_DST-1:0]              iss_mask,
    input  logic [MAX_DST-1:0][IDX_W-1:0]   iss_idx,
    input  logic [MAX_DST-1:0]              iss_wide,
    input  logic                            ex_valid,
    output logic                            ex_ready,
    input  logic                            ex_deferred,
    input  logic [MAX_DST-1:0]              ex_mask,
    input  logic [MAX_DST-1:0][IDX_W-1:0]   ex_idx,
    input  logic [MAX_DST-1:0]              ex_wide,
    input  logic                            cmp_valid,
    output logic                            cmp_ready,
    input  logic [IDX_W-1:0]                cmp_idx,
    input  logic                            cmp_wide,
    input  logic [DLY_W-1:0]                cmp_delay,
    input  logic                            q_valid,
    input  logic [MAX_OPS-1:0]              q_mask,
    input  logic [MAX_OPS-1:0][IDX_W-1:0]   q_idx,
    input  logic [MAX_OPS-1:0]              q_wide,
    input  logic [MAX_OPS-1:0]              q_is_dst,
    output logic                            q_ready,
    output logic [STALL_W-1:0]              stall_raw,
    output logic [STALL_W-1:0]              stall_waw
);

    if ((NUM_REGS % 2) != 0) begin : g_bad_even
        $error("vreg_scoreboard: register count must be even");
    end
    if ((NUM_REGS % MIN_ALLOC) != 0) begin : g_bad_granule
        $error("vreg_scoreboard: register count must be a multiple of the allocation granule");
    end

    logic [NUM_REGS-1:0]            pend_vec, lock_vec;
    logic [SLOT_W-1:0]              free_cnt, ex_need, ex_used;
    logic                           ex_fire, ex_take, cmp_take;
    logic [NUM_SLOTS-1:0]           rel_hit;
    logic [NUM_SLOTS-1:0][IDX_W-1:0] rel_idx;
    logic [NUM_SLOTS-1:0]           rel_wide;

    assign ex_need   = ex_deferred ? '0 : SLOT_W'($countones(ex_mask));
    assign ex_ready  = (free_cnt >= ex_need);
    assign ex_fire   = ex_valid && ex_ready;
    assign ex_take   = ex_fire && !ex_deferred;
    assign ex_used   = ex_take ? ex_need : '0;
    assign cmp_ready = (free_cnt > ex_used);
    assign cmp_take  = cmp_valid && cmp_ready;

    vsb_status #(
        .NUM_REGS (NUM_REGS),
        .MAX_DST  (MAX_DST),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_status (
        .clk     (clk),
        .rst     (rst),
        .iss_fire(iss_valid),
        .iss_mask(iss_mask),
        .iss_idx (iss_idx),
        .iss_wide(iss_wide),
        .ex_fire (ex_fire),
        .ex_mask (ex_mask),
        .ex_idx  (ex_idx),
        .ex_wide (ex_wide),
        .rel_hit (rel_hit),
        .rel_idx (rel_idx),
        .rel_wide(rel_wide),
        .pend    (pend_vec),
        .lock    (lock_vec)
    );

    vsb_release_pool #(
        .NUM_REGS (NUM_REGS),
        .MAX_DST  (MAX_DST),
        .NUM_SLOTS(NUM_SLOTS),
        .SP_LAT   (SP_LAT),
        .DP_LAT   (DP_LAT),
        .DLY_W    (DLY_W)
    ) u_pool (
        .clk      (clk),
        .rst      (rst),
        .ex_take  (ex_take),
        .ex_mask  (ex_mask),
        .ex_idx   (ex_idx),
        .ex_wide  (ex_wide),
        .cmp_take (cmp_take),
        .cmp_idx  (cmp_idx),
        .cmp_wide (cmp_wide),
        .cmp_delay(cmp_delay),
        .free_cnt (free_cnt),
        .rel_hit  (rel_hit),
        .rel_idx  (rel_idx),
        .rel_wide (rel_wide)
    );

    vsb_hazard #(
        .NUM_REGS(NUM_REGS),
        .MAX_OPS (MAX_OPS),
        .STALL_W (STALL_W)
    ) u_hazard (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend_vec),
        .lock     (lock_vec),
        .q_valid  (q_valid),
        .q_mask   (q_mask),
        .q_idx    (q_idx),
        .q_wide   (q_wide),
        .q_is_dst (q_is_dst),
        .q_ready  (q_ready),
        .stall_raw(stall_raw),
        .stall_waw(stall_waw)
    );

endmodule

// File: rtl/vsb_checker.sv
module vsb_checker #(
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned MAX_DST  = 2,
    parameter int unsigned MAX_OPS  = 4,
    parameter int unsigned STALL_W  = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            iss_valid,
    input logic [MAX_DST-1:0]              iss_mask,
    input logic [MAX_DST-1:0][IDX_W-1:0]   iss_idx,
    input logic                            ex_valid,
    input logic                            ex_ready,
    input logic [MAX_DST-1:0]              ex_mask,
    input logic [MAX_DST-1:0][IDX_W-1:0]   ex_idx,
    input logic [MAX_DST-1:0]              ex_wide,
    input logic                            q_valid,
    input logic [MAX_OPS-1:0]              q_mask,
    input logic [MAX_OPS-1:0][IDX_W-1:0]   q_idx,
    input logic                            q_ready,
    input logic [NUM_REGS-1:0]             pend_vec,
    input logic [NUM_REGS-1:0]             lock_vec,
    input logic [STALL_W-1:0]              stall_raw,
    input logic [STALL_W-1:0]              stall_waw
);

    // R4: an issued destination is pending one edge later
    a_r4_issue_pends: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_mask[0]) |=> pend_vec[$past(iss_idx[0])]);

    // R5: an accepted execute locks its destination and drops the pending flag
    a_r5_exec_locks: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_ready && ex_mask[0] && !iss_valid)
        |=> (lock_vec[$past(ex_idx[0])] && !pend_vec[$past(ex_idx[0])]));

    // R2: a wide destination also locks the next register, wrapping at the top
    a_r2_pair_wraps: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_ready && ex_mask[0] && ex_wide[0])
        |=> lock_vec[(int'($past(ex_idx[0])) + 1) % NUM_REGS]);

    // R3: an enabled operand on a held register blocks the query
    a_r3_held_blocks: assert property (@(posedge clk) disable iff (rst)
        (q_mask[0] && (lock_vec[q_idx[0]] || pend_vec[q_idx[0]])) |-> !q_ready);

    // R8: counters are frozen while no query is valid
    a_r8_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        !q_valid |=> ($stable(stall_raw) && $stable(stall_waw)));

    // R8: a valid ready query counts no stall
    a_r8_ready_no_count: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_ready) |=> ($stable(stall_raw) && $stable(stall_waw)));

    // R9: counters never decrease (saturate rather than wrap)
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        q_valid |=> ((stall_raw >= $past(stall_raw)) && (stall_waw >= $past(stall_waw))));

endmodule

bind vreg_scoreboard vsb_checker #(
    .NUM_REGS(NUM_REGS),
    .MAX_DST (MAX_DST),
    .MAX_OPS (MAX_OPS),
    .STALL_W (STALL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .iss_valid(iss_valid),
    .iss_mask (iss_mask),
    .iss_idx  (iss_idx),
    .ex_valid (ex_valid),
    .ex_ready (ex_ready),
    .ex_mask  (ex_mask),
    .ex_idx   (ex_idx),
    .ex_wide  (ex_wide),
    .q_valid  (q_valid),
    .q_mask   (q_mask),
    .q_idx    (q_idx),
    .q_ready  (q_ready),
    .pend_vec (pend_vec),
    .lock_vec (lock_vec),
    .stall_raw(stall_raw),
    .stall_waw(stall_waw)
);

// File: tb/tb_vreg_scoreboard.sv
`timescale 1ns/1ps
module tb_vreg_scoreboard;

    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             iss_valid = 0;
    logic [1:0]       iss_mask = 0;
    logic [1:0][5:0]  iss_idx = 0;
    logic [1:0]       iss_wide = 0;
    logic             ex_valid = 0, ex_deferred = 0;
    logic             ex_ready;
    logic [1:0]       ex_mask = 0;
    logic [1:0][5:0]  ex_idx = 0;
    logic [1:0]       ex_wide = 0;
    logic             cmp_valid = 0, cmp_wide = 0;
    logic             cmp_ready;
    logic [5:0]       cmp_idx = 0;
    logic [3:0]       cmp_delay = 0;
    logic             q_valid = 0;
    logic [3:0]       q_mask = 0;
    logic [3:0][5:0]  q_idx = 0;
    logic [3:0]       q_wide = 0, q_is_dst = 0;
    logic             q_ready;
    logic [SW-1:0]    stall_raw, stall_waw;

    vreg_scoreboard #(.STALL_W(SW)) dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_mask(iss_mask), .iss_idx(iss_idx), .iss_wide(iss_wide),
        .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_deferred(ex_deferred),
        .ex_mask(ex_mask), .ex_idx(ex_idx), .ex_wide(ex_wide),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_idx(cmp_idx),
        .cmp_wide(cmp_wide), .cmp_delay(cmp_delay),
        .q_valid(q_valid), .q_mask(q_mask), .q_idx(q_idx), .q_wide(q_wide),
        .q_is_dst(q_is_dst), .q_ready(q_ready),
        .stall_raw(stall_raw), .stall_waw(stall_waw)
    );

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [5:0] idx;
        logic       wide;
        logic [4:0] lat;
        logic [5:0] probe;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{6'd5,  1'b0, 5'd4, 6'd6},
        '{6'd10, 1'b1, 5'd8, 6'd11},
        '{6'd63, 1'b1, 5'd8, 6'd0},
        '{6'd0,  1'b0, 5'd4, 6'd1},
        '{6'd62, 1'b1, 5'd8, 6'd63},
        '{6'd33, 1'b0, 5'd4, 6'd34}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic q1(input int idx, input bit wide);
        q_mask = 4'b0001;
        q_idx = '0;
        q_idx[0] = 6'(idx);
        q_wide = {3'b000, wide};
        q_is_dst = '0;
        #1;
    endtask

    task automatic wait_free(input int idx, output int cyc);
        cyc = 0;
        q1(idx, 1'b0);
        while (!q_ready && cyc < 60) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic drive_ex(input bit defer, input logic [1:0] mask,
                            input int i0, input int i1, input logic [1:0] wide);
        ex_valid = 1'b1;
        ex_deferred = defer;
        ex_mask = mask;
        ex_idx[0] = 6'(i0);
        ex_idx[1] = 6'(i1);
        ex_wide = wide;
    endtask

    task automatic do_cmp(input int idx, input bit wide, input int dly);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_idx = 6'(idx);
        cmp_wide = wide;
        cmp_delay = 4'(dly);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        q_mask = 4'b1111;
        q_idx[0] = 6'd0; q_idx[1] = 6'd21; q_idx[2] = 6'd42; q_idx[3] = 6'd63;
        q_wide = 4'b1010;
        ex_mask = 2'b11;
        #1;
        chk(q_ready == 1'b1, "R1 query ready after reset", int'(q_ready), 1);
        chk(stall_raw == 0 && stall_waw == 0, "R1 counters zero", int'(stall_raw) + int'(stall_waw), 0);
        chk(ex_ready == 1'b1 && cmp_ready == 1'b1, "R1 ports ready", int'(ex_ready) + int'(cmp_ready), 2);
        ex_mask = 2'b00;

        // R2 R4 R5 R6: table of single-destination timed instructions
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            iss_valid = 1'b1;
            iss_mask = 2'b01;
            iss_idx[0] = VECS[v].idx;
            iss_wide[0] = VECS[v].wide;
            @(negedge clk);
            iss_valid = 1'b0;
            q1(int'(VECS[v].idx), 1'b0);
            chk(!q_ready, "R4 pending blocks", int'(q_ready), 0);
            q1(int'(VECS[v].probe), 1'b0);
            chk(q_ready == !VECS[v].wide, "R2 pair coverage", int'(q_ready), int'(!VECS[v].wide));
            drive_ex(1'b0, 2'b01, int'(VECS[v].idx), 0, {1'b0, VECS[v].wide});
            #1;
            chk(ex_ready, "R10 slot free", int'(ex_ready), 1);
            @(negedge clk);
            ex_valid = 1'b0;
            wait_free(int'(VECS[v].idx), cyc);
            chk(cyc == int'(VECS[v].lat), "R6 release latency", cyc, int'(VECS[v].lat));
        end

        // R3: disabled operands are ignored; wide query on free pair
        @(negedge clk);
        drive_ex(1'b1, 2'b01, 20, 0, 2'b00);
        @(negedge clk);
        ex_valid = 1'b0;
        q_mask = 4'b0010;
        q_idx[0] = 6'd20; q_idx[1] = 6'd18;
        q_wide = 4'b0000;
        #1;
        chk(q_ready, "R3 disabled operand ignored", int'(q_ready), 1);
        q_wide = 4'b0010; q_idx[1] = 6'd19;
        #1;
        chk(!q_ready, "R3 wide query hits locked neighbour", int'(q_ready), 0);

        // R7: deferred lock holds, completion releases after delay+1
        repeat (20) @(negedge clk);
        q1(20, 1'b0);
        chk(!q_ready, "R7 deferred lock held", int'(q_ready), 0);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_idx = 6'd20; cmp_wide = 1'b0; cmp_delay = 4'd3;
        #1;
        chk(cmp_ready, "R10 completion accepted", int'(cmp_ready), 1);
        @(negedge clk);
        cmp_valid = 1'b0;
        wait_free(20, cyc);
        chk(cyc == 4, "R7 completion delay", cyc, 4);

        // R8: first blocking operand decides the counter
        @(negedge clk);
        drive_ex(1'b1, 2'b01, 40, 0, 2'b01);
        @(negedge clk);
        ex_valid = 1'b0;
        q_mask = 4'b0111;
        q_idx[0] = 6'd5;  q_idx[1] = 6'd41; q_idx[2] = 6'd39;
        q_wide = 4'b0100;
        q_is_dst = 4'b0010;
        q_valid = 1'b1;
        repeat (3) @(negedge clk);
        q_valid = 1'b0;
        #1;
        chk(stall_waw == 3, "R8 destination stall counted", int'(stall_waw), 3);
        chk(stall_raw == 0, "R8 source not counted", int'(stall_raw), 0);
        q1(40, 1'b0);
        q_valid = 1'b1;
        @(negedge clk);
        q_valid = 1'b0;
        #1;
        chk(stall_raw == 1, "R8 source stall counted", int'(stall_raw), 1);

        // R9: saturation
        q_valid = 1'b1;
        repeat (20) @(negedge clk);
        q_valid = 1'b0;
        #1;
        chk(stall_raw == 15, "R9 raw saturates", int'(stall_raw), 15);
        chk(stall_waw == 3, "R9 waw unchanged", int'(stall_waw), 3);
        do_cmp(40, 1'b1, 0);
        wait_free(41, cyc);
        chk(cyc == 1, "R7 zero-delay wide completion", cyc, 1);

        // R10: slot exhaustion back-pressures timed execute and completion
        @(negedge clk);
        drive_ex(1'b0, 2'b11, 1, 2, 2'b00);
        @(negedge clk);
        drive_ex(1'b0, 2'b11, 3, 4, 2'b00);
        @(negedge clk);
        drive_ex(1'b0, 2'b01, 7, 0, 2'b00);
        cmp_idx = 6'd9;
        #1;
        chk(!ex_ready, "R10 timed execute stalled", int'(ex_ready), 0);
        chk(!cmp_ready, "R10 completion stalled", int'(cmp_ready), 0);
        ex_deferred = 1'b1;
        #1;
        chk(ex_ready, "R10 deferred needs no slot", int'(ex_ready), 1);
        ex_valid = 1'b0;
        ex_deferred = 1'b0;
        repeat (10) @(negedge clk);
        q1(4, 1'b0);
        chk(q_ready, "R6 burst registers released", int'(q_ready), 1);

        // R11: a new lock on the expiry edge wins
        @(negedge clk);
        drive_ex(1'b0, 2'b01, 50, 0, 2'b00);
        @(negedge clk);
        ex_valid = 1'b0;
        repeat (3) @(negedge clk);
        drive_ex(1'b1, 2'b01, 50, 0, 2'b00);
        @(negedge clk);
        ex_valid = 1'b0;
        ex_deferred = 1'b0;
        q1(50, 1'b0);
        chk(!q_ready, "R11 new mark survives expiry", int'(q_ready), 0);
        repeat (5) @(negedge clk);
        q1(50, 1'b0);
        chk(!q_ready, "R11 lock still held", int'(q_ready), 0);
        do_cmp(50, 1'b0, 0);
        wait_free(50, cyc);
        chk(cyc == 1, "R7 release after collision", cyc, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule